// File: doc/BRIEF.md
# Ripple-Carry ALU with Condition Flags

This block is an N-bit arithmetic and logic unit, 4 bits wide by default. It is built from a chain of identical one-bit stages. Each stage can complement its A bit and its B bit on request. From the two conditioned bits it forms an AND, an OR or a full-adder sum. The carry leaving each stage is the carry entering the stage above it. Four control lines set the function of the whole unit, and every stage sees the same settings:

- a complement-A line;
- a negate-B line, which complements every B bit and also supplies the carry into the lowest stage;
- a 2-bit function code.

Alongside the result, the unit reports zero, sign, carry-out and signed-overflow flags. It also reports two comparison flags that are meaningful when the unit is set up to subtract B from A.

- The signed less-than flag is the sign flag XOR the overflow flag. Because of this it stays correct when the difference overflows, which the sign bit alone does not.
- The equality flag is simply the zero flag of the difference. This needs no XOR gates per bit, and wrap-around cannot disturb it.

The path is purely combinational by default. A parameter adds one register stage at the outputs for timing tests.

Top module: `ripple_alu`

## Requirements
- R1: Function code 2'b00 gives the bitwise AND of the conditioned operands. The conditioned A is A, complemented when comp_a=1. The conditioned B is B, complemented when neg_b=1.
- R2: Function code 2'b01 gives the bitwise OR of the conditioned operands.
- R3: Function code 2'b10 gives (conditioned A + conditioned B + neg_b) mod 2^WIDTH. The carry ripples from bit 0 upward.
- R4: Function code 2'b11 gives an all-zero result.
- R5: With comp_a=0, neg_b=1 and code 2'b10, the result is (A − B) mod 2^WIDTH.
- R6: With comp_a=1, neg_b=1 and code 2'b10, the result is (−A − B − 1) mod 2^WIDTH.
- R7: flag_zero is 1 exactly when the result is all zeros. flag_sign equals the result's top bit.
- R8: flag_carry is the carry out of the top adder stage, for every function code.
- R9: flag_ovf is the carry into the top adder stage XOR the carry out of it, for every function code.
- R10: In the subtract setting of R5, flag_lt is 1 exactly when A < B as two's-complement numbers. This holds for every operand pair, including pairs whose difference overflows.
- R11: In the subtract setting of R5, flag_eq is 1 exactly when A equals B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Active-low asynchronous reset |
| opnd_a | input | WIDTH | Operand A |
| opnd_b | input | WIDTH | Operand B |
| comp_a | input | 1 | Complement A in every stage |
| neg_b | input | 1 | Complement B in every stage and set the lowest carry-in |
| func | input | 2 | Function code: 00 AND, 01 OR, 10 sum, 11 zero |
| result | output | WIDTH | Selected result word |
| flag_zero | output | 1 | Result is zero |
| flag_sign | output | 1 | Top bit of the result |
| flag_carry | output | 1 | Carry out of the top stage |
| flag_ovf | output | 1 | Signed overflow of the adder chain |
| flag_lt | output | 1 | Signed A < B (subtract setting) |
| flag_eq | output | 1 | A equals B (subtract setting) |

## Verification
The bench sweeps every operand pair in the subtract setting, and it directs extra vectors at the overflow boundary, such as 7 against −8 and −8 against 1. A design that takes less-than from the sign bit alone inverts the answer on exactly those pairs. An overflow flag built from the wrong carries misreads them as well.

Random vectors across all control settings catch the following faults:
- a negate line that fails to feed the lowest carry-in, which leaves subtraction off by one;
- a complement-A path that is missing, which breaks the −A−B−1 case;
- a carry flag that is gated by the function code, which goes silent under AND or OR.

// File: rtl/alu_pkg.sv
package alu_pkg;
   typedef enum logic [1:0] {
      FN_AND  = 2'b00,
      FN_OR   = 2'b01,
      FN_SUM  = 2'b10,
      FN_NULL = 2'b11
   } alu_fn_e;

   typedef struct packed {
      logic zero;
      logic sign;
      logic carry;
      logic ovf;
      logic lt;
      logic eq;
   } alu_flags_t;
endpackage

// File: rtl/alu_bit_stage.sv
module alu_bit_stage
   import alu_pkg::*;
(
   input  logic    a_i,
   input  logic    b_i,
   input  logic    comp_a_i,
   input  logic    comp_b_i,
   input  logic    cin_i,
   input  alu_fn_e fn_i,
   output logic    res_o,
   output logic    cout_o
);
   logic a_c, b_c, s_bit;

   always_comb begin
      a_c    = a_i ^ comp_a_i;
      b_c    = b_i ^ comp_b_i;
      s_bit  = a_c ^ b_c ^ cin_i;
      cout_o = (a_c & b_c) | (cin_i & (a_c | b_c));
      unique case (fn_i)
         FN_AND:  res_o = a_c & b_c;
         FN_OR:   res_o = a_c | b_c;
         FN_SUM:  res_o = s_bit;
         default: res_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
   import alu_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] res_i,
   input  logic             cin_top_i,
   input  logic             cout_top_i,
   output alu_flags_t       flags_o
);
   always_comb begin
      flags_o.zero  = ~|res_i;
      flags_o.sign  = res_i[WIDTH-1];
      flags_o.carry = cout_top_i;
      flags_o.ovf   = cin_top_i ^ cout_top_i;
      flags_o.lt    = res_i[WIDTH-1] ^ (cin_top_i ^ cout_top_i);
      flags_o.eq    = ~|res_i;
   end
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
   import alu_pkg::*;
#(
   parameter int WIDTH   = 4,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic             comp_a,
   input  logic             neg_b,
   input  logic [1:0]       func,
   output logic [WIDTH-1:0] result,
   output logic             flag_zero,
   output logic             flag_sign,
   output logic             flag_carry,
   output logic             flag_ovf,
   output logic             flag_lt,
   output logic             flag_eq
);
   localparam int TOP = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_width_chk
         initial $fatal(1, "ripple_alu: WIDTH must be at least 2");
      end
   endgenerate

   alu_fn_e          fn;
   logic [WIDTH:0]   cy;
   logic [WIDTH-1:0] res_c;
   alu_flags_t       flg_c;
   logic [WIDTH-1:0] res_q;
   alu_flags_t       flg_q;

   assign fn    = alu_fn_e'(func);
   assign cy[0] = neg_b;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         alu_bit_stage u_stage (
            .a_i      (opnd_a[i]),
            .b_i      (opnd_b[i]),
            .comp_a_i (comp_a),
            .comp_b_i (neg_b),
            .cin_i    (cy[i]),
            .fn_i     (fn),
            .res_o    (res_c[i]),
            .cout_o   (cy[i+1])
         );
      end
   endgenerate

   alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
      .res_i      (res_c),
      .cin_top_i  (cy[TOP]),
      .cout_top_i (cy[WIDTH]),
      .flags_o    (flg_c)
   );

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               res_q <= '0;
               flg_q <= '0;
            end else begin
               res_q <= res_c;
               flg_q <= flg_c;
            end
         end
      end else begin : g_comb
         assign res_q = res_c;
         assign flg_q = flg_c;
      end
   endgenerate

   assign result     = res_q;
   assign flag_zero  = flg_q.zero;
   assign flag_sign  = flg_q.sign;
   assign flag_carry = flg_q.carry;
   assign flag_ovf   = flg_q.ovf;
   assign flag_lt    = flg_q.lt;
   assign flag_eq    = flg_q.eq;

   logic sub_mode, add_mode;
   assign sub_mode = !comp_a && neg_b && (fn == FN_SUM);
   assign add_mode = !comp_a && !neg_b && (fn == FN_SUM);

   AST_SUB_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
      sub_mode |-> (res_c == opnd_a - opnd_b)); // R5
   AST_LT_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      sub_mode |-> (flg_c.lt == ($signed(opnd_a) < $signed(opnd_b)))); // R10
   AST_EQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      sub_mode |-> (flg_c.eq == (opnd_a == opnd_b))); // R11
   AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      add_mode |-> ({flg_c.carry, res_c} == ({1'b0, opnd_a} + {1'b0, opnd_b}))); // R8
   AST_NULL_FN: assert property (@(posedge clk) disable iff (!rst_n)
      (fn == FN_NULL) |-> (res_c == '0)); // R4
endmodule

// File: tb/ripple_alu_tb_top.sv
module ripple_alu_tb_top;
   localparam int W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] a = '0, b = '0;
   logic ca = 1'b0, nb = 1'b0;
   logic [1:0] fn = 2'b00;
   logic [W-1:0] res;
   logic fz, fs, fc, fo, flt, feq;

   int n_vec = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   ripple_alu #(.WIDTH(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .opnd_a(a), .opnd_b(b),
      .comp_a(ca), .neg_b(nb), .func(fn),
      .result(res), .flag_zero(fz), .flag_sign(fs), .flag_carry(fc),
      .flag_ovf(fo), .flag_lt(flt), .flag_eq(feq)
   );

   function automatic int exp_res(int xa, int xb, bit c, bit n, int f);
      int ea = c ? (~xa & 15) : xa;
      int eb = n ? (~xb & 15) : xb;
      case (f)
         0: return ea & eb;
         1: return ea | eb;
         2: return (ea + eb + int'(n)) & 15;
         default: return 0;
      endcase
   endfunction

   function automatic bit exp_carry(int xa, int xb, bit c, bit n);
      int ea = c ? (~xa & 15) : xa;
      int eb = n ? (~xb & 15) : xb;
      return ((ea + eb + int'(n)) >> 4) & 1;
   endfunction

   function automatic bit exp_ovf(int xa, int xb, bit c, bit n);
      int ea = c ? (~xa & 15) : xa;
      int eb = n ? (~xb & 15) : xb;
      bit c3 = (((ea & 7) + (eb & 7) + int'(n)) >> 3) & 1;
      return c3 ^ exp_carry(xa, xb, c, n);
   endfunction

   function automatic int sgn(int x);
      return (x >= 8) ? x - 16 : x;
   endfunction

   task automatic cmp(string req, int got, int exp);
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (a=%0d b=%0d ca=%0b nb=%0b fn=%0d)",
                  req, got, exp, a, b, ca, nb, fn);
      end
   endtask

   task automatic apply(int xa, int xb, bit c, bit n, int f);
      int er;
      @(negedge clk);
      a = W'(xa); b = W'(xb); ca = c; nb = n; fn = 2'(f);
      #1;
      n_vec++;
      er = exp_res(xa, xb, c, n, f);
      case (f)
         0: cmp("R1 and", int'(res), er);
         1: cmp("R2 or", int'(res), er);
         2: cmp("R3 sum", int'(res), er);
         default: cmp("R4 null", int'(res), er);
      endcase
      cmp("R7 zero", int'(fz), int'(er == 0));
      cmp("R7 sign", int'(fs), (er >> 3) & 1);
      cmp("R8 carry", int'(fc), int'(exp_carry(xa, xb, c, n)));
      cmp("R9 ovf", int'(fo), int'(exp_ovf(xa, xb, c, n)));
      if (f == 2 && !c && n) begin
         cmp("R5 diff", int'(res), (xa - xb) & 15);
         cmp("R10 lt", int'(flt), int'(sgn(xa) < sgn(xb)));
         cmp("R11 eq", int'(feq), int'(xa == xb));
      end
      if (f == 2 && c && n)
         cmp("R6 negsum", int'(res), (-xa - xb - 1) & 15);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : stim
      int seed;
      seed = 17;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      // reset-time outputs with all-zero controls: AND of zeros, R7
      @(negedge clk);
      n_vec++;
      cmp("R7 reset result", int'(res), 0);
      cmp("R7 reset zero", int'(fz), 1);
      rst_n = 1'b1;
      // directed overflow corners for R10 and R9
      apply(7, 8, 0, 1, 2);
      apply(8, 7, 0, 1, 2);
      apply(8, 1, 0, 1, 2);
      apply(1, 8, 0, 1, 2);
      apply(5, 5, 0, 1, 2);
      apply(15, 15, 1, 1, 2);  // R6
      apply(0, 0, 1, 1, 2);    // R6
      apply(15, 15, 0, 0, 2);  // R8 carry out
      apply(7, 1, 0, 0, 2);    // R9 positive overflow
      apply(12, 10, 0, 0, 3);  // R4, R8 flags still report chain
      apply(12, 10, 1, 0, 0);  // R1 with complement
      apply(12, 10, 0, 1, 1);  // R2 with negate
      // exhaustive subtract sweep: R5, R10, R11
      for (int i = 0; i < 16; i++)
         for (int j = 0; j < 16; j++)
            apply(i, j, 0, 1, 2);
      // random mix across all settings
      for (int k = 0; k < 2000; k++)
         apply(int'($urandom() & 15), int'($urandom() & 15),
               bit'($urandom() & 1), bit'($urandom() & 1), int'($urandom() & 3));
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule